// File: doc/BRIEF.md
# Carry-Discipline Integer Add/Subtract Unit

This block performs one 32-bit addition or subtraction per issue cycle for a stack-machine execution pipe. It owns a single carry flag and applies one of four carry disciplines to every operation. The trapping discipline folds the carry into the sum and then clears it, and requests a trap on signed overflow. The unsigned discipline folds the carry in and loads it back with the carry out or borrow. The plain discipline ignores the carry entirely. The list-language discipline ignores the incoming carry and clears it. Operand fetch, decode and trap handling belong to the surrounding pipe.

The second operand can also come from a zero-extended 8-bit or 16-bit literal. Literal forms always use the trapping discipline. Results, the write strobe, the carry flag and the trap strobe are registered, so every issue is answered on the next clock edge. A requested trap suppresses the write of both the result and the carry.

Top module: `addsub_unit`

## Requirements
- R1: While reset is asserted and after its release, `result_o` and `carry_o` are 0 and `wr_o` and `trap_o` are low until the first issue.
- R2: With `mode_i`=0 (trapping) and no overflow, one cycle after issue `result_o` equals a+b+carry (`sub_i`=0) or a-b-carry (`sub_i`=1) modulo 2^32, `wr_o` pulses high, and `carry_o` becomes 0.
- R3: In trapping operations, signed overflow occurs when the exact two's-complement result lies outside [-2^31, 2^31-1]. In that case `trap_o` is high for exactly the following cycle, `wr_o` stays low, and `result_o` and `carry_o` keep their previous values.
- R4: With `mode_i`=1 (unsigned), the result includes the carry flag, `carry_o` becomes the unsigned carry out (add) or the borrow, set when a < b+carry as unsigned (sub), and no trap is raised.
- R5: With `mode_i`=2 (plain), the result is a+b or a-b whatever the carry, `carry_o` is unchanged, and no trap is raised.
- R6: With `mode_i`=3 (list-language), the result is a+b or a-b whatever the carry, `carry_o` becomes 0, and no trap is raised.
- R7: `src_i`=1 selects `lit_i[7:0]` and `src_i`=2 selects `lit_i[15:0]`, zero-extended, as the second operand. Both use trapping behaviour whatever `mode_i` is. `src_i`=0 or 3 selects `opb_i`.
- R8: When `valid_i` is low, `result_o` and `carry_o` hold and `wr_o` and `trap_o` are low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Issue strobe for one operation |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| mode_i | input | 2 | Carry discipline: 0 trapping, 1 unsigned, 2 plain, 3 list-language |
| src_i | input | 2 | Second operand: 0/3 register, 1 byte literal, 2 halfword literal |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand when register source |
| lit_i | input | 16 | Literal field |
| result_o | output | 32 | Last written result |
| wr_o | output | 1 | One-cycle pulse: result written |
| carry_o | output | 1 | Carry flag |
| trap_o | output | 1 | One-cycle overflow trap request |

## Verification
Every output is one register stage behind the issue, so the result, the write pulse, the carry flag and the trap strobe are all due at the first rising edge after `valid_i` is sampled. The bench drives on the falling edge and compares all four on the next falling edge. Before each operation, a conditioning issue sets the carry to a chosen state. That conditioning issue is checked too, so the carry state for each sweep point is known. The sweep covers boundary operand pairs in both carry states across all modes and both operations. A bench-side model with wide signed and unsigned arithmetic supplies the expected values, and the held values after a trap or an idle cycle are compared against the previous expectation.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    MODE_TRAP  = 2'd0,
    MODE_UNS   = 2'd1,
    MODE_PLAIN = 2'd2,
    MODE_LIST  = 2'd3
  } carry_mode_e;

  typedef enum logic [1:0] {
    SRC_REG   = 2'd0,
    SRC_LIT8  = 2'd1,
    SRC_LIT16 = 2'd2,
    SRC_RSV   = 2'd3
  } opnd_src_e;
endpackage

// File: rtl/addsub_opsel.sv
module addsub_opsel
  import addsub_pkg::*;
#(
  parameter int W     = 32,
  parameter int LIT_W = 16
) (
  input  opnd_src_e        src,
  input  carry_mode_e      mode_in,
  input  logic [W-1:0]     opb,
  input  logic [LIT_W-1:0] lit,
  output logic [W-1:0]     y,
  output carry_mode_e      mode_eff
);
  localparam int BYTE_W = LIT_W / 2;

  logic [W-1:0] lit_full;
  logic [W-1:0] lit_byte;

  generate
    if (W > LIT_W) begin : g_pad
      assign lit_full = {{(W-LIT_W){1'b0}}, lit};
    end else begin : g_trunc
      assign lit_full = lit[W-1:0];
    end
    if (W > BYTE_W) begin : g_bpad
      assign lit_byte = {{(W-BYTE_W){1'b0}}, lit[BYTE_W-1:0]};
    end else begin : g_btrunc
      assign lit_byte = lit[W-1:0];
    end
  endgenerate

  always_comb begin
    y        = opb;
    mode_eff = mode_in;
    unique case (src)
      SRC_LIT8:  begin y = lit_byte; mode_eff = MODE_TRAP; end
      SRC_LIT16: begin y = lit_full; mode_eff = MODE_TRAP; end
      default:   begin y = opb; mode_eff = mode_in; end
    endcase
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int W = 32
) (
  input  logic         sub,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
    else     ext = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    res  = ext[W-1:0];
    cout = ext[W];
    if (sub) ovf = (x[W-1] != y[W-1]) && (res[W-1] != x[W-1]);
    else     ovf = (x[W-1] == y[W-1]) && (res[W-1] != x[W-1]);
  end
endmodule

// File: rtl/addsub_flagctl.sv
module addsub_flagctl
  import addsub_pkg::*;
(
  input  logic        valid,
  input  carry_mode_e mode,
  input  logic        carry_cur,
  input  logic        cout,
  input  logic        ovf,
  output logic        cin,
  output logic        trap_req,
  output logic        res_en,
  output logic        carry_en,
  output logic        carry_nxt
);
  always_comb begin
    cin       = ((mode == MODE_TRAP) || (mode == MODE_UNS)) ? carry_cur : 1'b0;
    trap_req  = valid && (mode == MODE_TRAP) && ovf;
    res_en    = valid && !trap_req;
    carry_en  = 1'b0;
    carry_nxt = carry_cur;
    if (res_en) begin
      unique case (mode)
        MODE_TRAP:  begin carry_en = 1'b1; carry_nxt = 1'b0; end
        MODE_UNS:   begin carry_en = 1'b1; carry_nxt = cout; end
        MODE_LIST:  begin carry_en = 1'b1; carry_nxt = 1'b0; end
        default:    begin carry_en = 1'b0; carry_nxt = carry_cur; end
      endcase
    end
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int W     = 32,
  parameter int LIT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             sub_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       src_i,
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  input  logic [LIT_W-1:0] lit_i,
  output logic [W-1:0]     result_o,
  output logic             wr_o,
  output logic             carry_o,
  output logic             trap_o
);
  logic [1:0] rst_pipe;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  logic [W-1:0] y_sel;
  carry_mode_e  mode_eff;
  logic [W-1:0] sum;
  logic         cout, ovf, cin;
  logic         trap_req, res_en, carry_en, carry_nxt;

  addsub_opsel #(.W(W), .LIT_W(LIT_W)) u_opsel (
    .src      (opnd_src_e'(src_i)),
    .mode_in  (carry_mode_e'(mode_i)),
    .opb      (opb_i),
    .lit      (lit_i),
    .y        (y_sel),
    .mode_eff (mode_eff)
  );

  addsub_core #(.W(W)) u_core (
    .sub  (sub_i),
    .x    (opa_i),
    .y    (y_sel),
    .cin  (cin),
    .res  (sum),
    .cout (cout),
    .ovf  (ovf)
  );

  addsub_flagctl u_flag (
    .valid     (valid_i),
    .mode      (mode_eff),
    .carry_cur (carry_o),
    .cout      (cout),
    .ovf       (ovf),
    .cin       (cin),
    .trap_req  (trap_req),
    .res_en    (res_en),
    .carry_en  (carry_en),
    .carry_nxt (carry_nxt)
  );

  logic [W-1:0] result_d;
  logic         carry_d, wr_d, trap_d;

  always_comb begin
    result_d = result_o;
    carry_d  = carry_o;
    if (res_en)   result_d = sum;
    if (carry_en) carry_d  = carry_nxt;
    wr_d   = res_en;
    trap_d = trap_req;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      wr_o     <= 1'b0;
      trap_o   <= 1'b0;
    end else begin
      result_o <= result_d;
      carry_o  <= carry_d;
      wr_o     <= wr_d;
      trap_o   <= trap_d;
    end
  end

  // R3: trap and write never coincide; a trap leaves result and carry alone
  p_trap_no_write_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    trap_o |-> !wr_o);
  p_trap_hold_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    trap_o |-> (result_o == $past(result_o)) && (carry_o == $past(carry_o)));
  // R4, R5, R6: non-trapping register-source modes never trap
  p_no_trap_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (valid_i && (mode_i != 2'd0) && ((src_i == 2'd0) || (src_i == 2'd3))) |=> !trap_o);
  // R5: plain mode keeps the carry
  p_plain_carry_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (valid_i && (mode_i == 2'd2) && ((src_i == 2'd0) || (src_i == 2'd3))) |=> $stable(carry_o));
  // R6: list-language mode clears the carry
  p_list_clear_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (valid_i && (mode_i == 2'd3) && ((src_i == 2'd0) || (src_i == 2'd3))) |=> !carry_o);
  // R8: idle cycles change nothing
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !valid_i |=> !wr_o && !trap_o && $stable(carry_o) && $stable(result_o));
  // R3: trap strobe lasts one cycle per issue
  p_trap_pulse_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (trap_o && !$past(valid_i)) |-> 1'b0);
endmodule

// File: tb/test_addsub_unit.sv
`timescale 1ns/1ps
module test_addsub_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, sub_i;
  logic [1:0]  mode_i, src_i;
  logic [31:0] opa_i, opb_i;
  logic [15:0] lit_i;
  logic [31:0] result_o;
  logic        wr_o, carry_o, trap_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] exp_res;
  logic        exp_c;

  always #2 clk = ~clk;

  addsub_unit i_addsub_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .sub_i(sub_i),
    .mode_i(mode_i), .src_i(src_i), .opa_i(opa_i), .opb_i(opb_i),
    .lit_i(lit_i), .result_o(result_o), .wr_o(wr_o),
    .carry_o(carry_o), .trap_o(trap_o)
  );

  task automatic check(input string tag, input logic [31:0] r, input logic c,
                       input logic w, input logic t);
    n_chk++;
    if (result_o !== r || carry_o !== c || wr_o !== w || trap_o !== t) begin
      n_bad++;
      $display("FAIL %s: res=%h c=%b wr=%b trap=%b, expected res=%h c=%b wr=%b trap=%b",
               tag, result_o, carry_o, wr_o, trap_o, r, c, w, t);
    end
  endtask

  task automatic issue(input logic sb, input logic [1:0] md, input logic [1:0] sr,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] lt);
    logic [31:0] y;
    logic [1:0]  em;
    logic        ci, ovf, co, tr;
    longint      sx, sy, st, ux, uy, ut;
    string       tag;
    y  = (sr == 2'd1) ? {24'd0, lt[7:0]} : (sr == 2'd2) ? {16'd0, lt} : b;
    em = (sr == 2'd1 || sr == 2'd2) ? 2'd0 : md;
    ci = (em <= 2'd1) ? exp_c : 1'b0;
    sx = longint'($signed(a));
    sy = longint'($signed(y));
    st = sb ? (sx - sy - longint'(ci)) : (sx + sy + longint'(ci));
    ovf = (st > 64'sd2147483647) || (st < -64'sd2147483648);
    ux = longint'({32'd0, a});
    uy = longint'({32'd0, y});
    ut = sb ? (ux - uy - longint'(ci)) : (ux + uy + longint'(ci));
    co = sb ? (ux < uy + longint'(ci)) : ut[32];
    tr = (em == 2'd0) && ovf;
    if (sr == 2'd1 || sr == 2'd2) tag = "R7";
    else if (em == 2'd0) tag = tr ? "R3" : "R2";
    else if (em == 2'd1) tag = "R4";
    else if (em == 2'd2) tag = "R5";
    else tag = "R6";
    if (!tr) begin
      exp_res = ut[31:0];
      if (em == 2'd1) exp_c = co;
      else if (em != 2'd2) exp_c = 1'b0;
    end
    valid_i = 1'b1; sub_i = sb; mode_i = md; src_i = sr;
    opa_i = a; opb_i = b; lit_i = lt;
    @(negedge clk);
    check(tag, exp_res, exp_c, !tr, tr);
    valid_i = 1'b0;
  endtask

  task automatic set_carry(input logic v);
    if (v) issue(1'b0, 2'd1, 2'd0, 32'hFFFF_FFFF, 32'd1, 16'd0);
    else   issue(1'b0, 2'd3, 2'd0, 32'd0, 32'd0, 16'd0);
  endtask

  logic [31:0] vals [12];

  initial begin
    vals = '{32'd0, 32'd1, 32'd2, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0001,
             32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h1234_5678, 32'h0000_FFFF,
             32'h7FFF_FFFE, 32'hA5A5_A5A5};
    rst_n = 1'b0; valid_i = 1'b0; sub_i = 1'b0; mode_i = 2'd0; src_i = 2'd0;
    opa_i = '0; opb_i = '0; lit_i = '0;
    exp_res = '0; exp_c = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 32'd0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 32'd0, 1'b0, 1'b0, 1'b0);

    for (int ci = 0; ci < 2; ci++)
      for (int md = 0; md < 4; md++)
        for (int sb = 0; sb < 2; sb++)
          for (int ia = 0; ia < 12; ia++)
            for (int ib = 0; ib < 12; ib++) begin
              set_carry(ci[0]);
              issue(sb[0], md[1:0], (ia == 3) ? 2'd3 : 2'd0, vals[ia], vals[ib], 16'hBEEF);
            end

    // R7: literal sources under every requested mode and both carry states
    for (int ci = 0; ci < 2; ci++)
      for (int md = 0; md < 4; md++)
        for (int sr = 1; sr < 3; sr++)
          for (int ia = 0; ia < 12; ia++) begin
            set_carry(ci[0]);
            issue(ia[0], md[1:0], sr[1:0], vals[ia], 32'h5555_5555, 16'hFF80 ^ 16'(ia * 16'h1111));
          end

    // R8: idle cycles with busy inputs leave state alone
    set_carry(1'b1);
    for (int k = 0; k < 6; k++) begin
      sub_i = k[0]; mode_i = k[1:0]; src_i = 2'd0;
      opa_i = 32'h7FFF_FFFF; opb_i = 32'h8000_0000; lit_i = 16'hFFFF;
      @(negedge clk);
      check("R8", exp_res, exp_c, 1'b0, 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule